// File: doc/BRIEF.md
# Real-Time Clock and Calendar with Alarm

This block keeps time of day and a simple calendar for a host processor on a small register bus. A fast reference clock, which is the block's own clock, is divided by a programmable prescaler into a one-per-second tick. The tick drives a BCD chain of seconds, minutes, hours, day-of-month and month. The host reads and writes each counter at its own address. A single control byte starts or stops the chain, sets the prescaler divisor, picks one of fifteen square waves for a clock output, and sets an alarm mode.

In alarm mode, writes to the three time addresses load hidden alarm latches and leave the counters alone. An alarm match raises an active-low interrupt. A rising edge on the selected square wave also raises it. A read-only status byte shows which source fired, and reading that byte clears the interrupt.

Reads of the date and time fields come from a copy that is captured when the seconds counter is read. A tick that falls between byte reads therefore cannot produce a torn time.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the counters read 00:00:00, date 01, month 01. The control byte is 0x00 (stopped). `irq_n` is 1, `clkout` is 0, `rdata` is 0x00 and status reads 0x00.
- R2: Control bit 0 is run. While it is 1 the seconds counter advances once every `DIV_BASE << sel` clocks, where `sel` is control bits 2:1. While it is 0 no counter advances.
- R3: The counters are BCD. Seconds and minutes go 59 -> 00 and carry. Hours go 23 -> 00 and carry. Date goes to 01 after the last day of the month (28 for month 02; 30 for months 04, 06, 09, 11; 31 otherwise) and carries. Month goes 12 -> 01.
- R4: Addresses: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 7 control/status. A read strobe puts the data on `rdata` one clock later. Addresses 5 and 6 read 0x00, and writes to them change nothing.
- R5: A write to address 7 loads the control byte: bit 0 run, bits 2:1 prescaler select, bit 3 alarm mode, bits 7:4 wave select. The control byte cannot be read back; a read of address 7 returns status.
- R6: When control bit 3 is 1, writes to addresses 0, 1 and 2 load the seconds, minutes and hours alarm latches and leave the counters unchanged. Date and month writes still reach the counters.
- R7: When control bit 3 is 1 and seconds, minutes and hours become equal to the alarm latches, status bit 7 is set and `irq_n` goes low on the next clock. When bit 3 is 0, a match has no effect.
- R8: `clkout` is the registered selected wave. Select 0 gives a constant 0. Selects 1 to 8 give bit 0 to 7 of a free-running reference divider, so select 1 toggles every clock. Select 9 gives the prescaler half-second phase. Selects 10 to 15 give, in turn, the LSB of seconds units, the LSB of seconds tens, the LSB of minutes units, the LSB of hours units, the LSB of date units and the LSB of month units.
- R9: A rising edge of the selected wave sets status bit 6 and drives `irq_n` low.
- R10: A read of address 7 returns {alarm flag, wave flag, 000000}, clears both flags, and returns `irq_n` to 1 on the next clock unless a new event arrives in that same cycle.
- R11: A counter write to seconds restarts the prescaler, so the next advance comes one full divisor period after the write.
- R12: A read of seconds captures minutes, hours, date and month. Reads of addresses 1 to 4 return that captured copy, not the live counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, also the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register address |
| wr | input | 1 | Write strobe, one clock per access |
| rd | input | 1 | Read strobe, one clock per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid one clock after `rd` |
| irq_n | output | 1 | Interrupt, active low |
| clkout | output | 1 | Selected square wave |

## Verification
The checker watches, on every cycle, the local rules of the chain and the bus:
- a stopped chain holds seconds steady;
- seconds wrap from 59 to 00 on a tick;
- a tick is never followed by a second tick;
- a counter write lands and an alarm-mode write leaves the counter alone;
- an alarm match pulls the interrupt low;
- a quiet status read releases it.

Only the bench scenarios can show the things that span many cycles or need exact timing: the absolute divisor periods for each prescaler select, month-length and year-end carries, the prescaler restart after a seconds write, the snapshot that hides a tick between byte reads, and the timing of the wave-driven interrupt.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NUM_CNT    = 5;
    localparam int NUM_ALARM  = 3;
    localparam int REF_BITS   = 8;
    localparam int WAVE_SRCS  = 16;
    localparam int ST_ALARM   = 7;
    localparam int ST_WAVE    = 6;

    typedef enum logic [2:0] {
        A_SEC  = 3'd0,
        A_MIN  = 3'd1,
        A_HR   = 3'd2,
        A_DATE = 3'd3,
        A_MON  = 3'd4,
        A_RSV5 = 3'd5,
        A_RSV6 = 3'd6,
        A_CTRL = 3'd7
    } rtc_addr_e;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hr;
        logic [7:0] date;
        logic [7:0] mon;
    } rtc_time_t;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hr;
    } rtc_alarm_t;

    typedef struct packed {
        logic [3:0] wave_sel;
        logic       alarm_mode;
        logic [1:0] pre_sel;
        logic       run;
    } rtc_ctrl_t;

    localparam rtc_time_t TIME_RESET = '{sec: 8'h00, min: 8'h00, hr: 8'h00,
                                         date: 8'h01, mon: 8'h01};

    // Returns {wrapped, next value} for one BCD step
    function automatic logic [8:0] bcd_step(input logic [7:0] v,
                                            input logic [7:0] last,
                                            input logic [7:0] first);
        if (v == last)
            return {1'b1, first};
        if (v[3:0] == 4'd9)
            return {1'b0, v[7:4] + 4'd1, 4'd0};
        return {1'b0, v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [7:0] month_last_day(input logic [7:0] mon);
        case (mon)
            8'h02:                      return 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtc_pkg::*;
#(
    parameter int DIV_BASE = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic                clear,
    input  logic [1:0]          pre_sel,
    output logic                tick,
    output logic                half_wave,
    output logic [REF_BITS-1:0] ref_cnt
);

    localparam int MAX_DIV = DIV_BASE * 8;
    localparam int PW      = $clog2(MAX_DIV) + 1;

    logic [PW-1:0] div_w;
    logic [PW-1:0] cnt_q;

    assign div_w     = PW'(DIV_BASE) << pre_sel;
    assign half_wave = (cnt_q >= (div_w >> 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (!run || clear) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q == div_w - PW'(1)) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + PW'(1);
            tick  <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ref_cnt <= '0;
        else
            ref_cnt <= ref_cnt + REF_BITS'(1);
    end

endmodule

// File: rtl/rtc_counter_chain.sv
module rtc_counter_chain
    import rtc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic [NUM_CNT-1:0] wr_en,
    input  logic [7:0]         wdata,
    output rtc_time_t          now
);

    rtc_time_t  nxt;
    logic [8:0] st_sec, st_min, st_hr, st_date, st_mon;
    logic       adv;

    // A seconds write restarts the second, so it also swallows a tick
    assign adv = tick & ~wr_en[0];

    always_comb begin
        st_sec  = bcd_step(now.sec,  8'h59, 8'h00);
        st_min  = bcd_step(now.min,  8'h59, 8'h00);
        st_hr   = bcd_step(now.hr,   8'h23, 8'h00);
        st_date = bcd_step(now.date, month_last_day(now.mon), 8'h01);
        st_mon  = bcd_step(now.mon,  8'h12, 8'h01);

        nxt = now;
        if (adv) begin
            nxt.sec = st_sec[7:0];
            if (st_sec[8]) begin
                nxt.min = st_min[7:0];
                if (st_min[8]) begin
                    nxt.hr = st_hr[7:0];
                    if (st_hr[8]) begin
                        nxt.date = st_date[7:0];
                        if (st_date[8])
                            nxt.mon = st_mon[7:0];
                    end
                end
            end
        end

        if (wr_en[0]) nxt.sec  = wdata;
        if (wr_en[1]) nxt.min  = wdata;
        if (wr_en[2]) nxt.hr   = wdata;
        if (wr_en[3]) nxt.date = wdata;
        if (wr_en[4]) nxt.mon  = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)
            now <= TIME_RESET;
        else
            now <= nxt;
    end

endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
    import rtc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  rtc_time_t            now,
    input  logic [NUM_ALARM-1:0] latch_wr,
    input  logic [7:0]           wdata,
    input  logic                 alarm_mode,
    input  logic [3:0]           wave_sel,
    input  logic [REF_BITS-1:0]  ref_cnt,
    input  logic                 half_wave,
    input  logic                 status_rd,
    output logic                 alarm_hit,
    output logic                 irq_n,
    output logic                 clkout,
    output logic [7:0]           status
);

    rtc_alarm_t           alm_q;
    logic                 hit_q;
    logic                 alarm_f, wave_f;
    logic [WAVE_SRCS-1:0] src;
    logic                 wave_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            alm_q <= '0;
        end else begin
            if (latch_wr[0]) alm_q.sec <= wdata;
            if (latch_wr[1]) alm_q.min <= wdata;
            if (latch_wr[2]) alm_q.hr  <= wdata;
        end
    end

    assign alarm_hit = alarm_mode && (now.sec == alm_q.sec) &&
                       (now.min == alm_q.min) && (now.hr == alm_q.hr);

    // Wave sources: 0 off, 1..8 reference divider, 9 prescaler, 10..15 counters
    assign src[0] = 1'b0;
    for (genvar i = 0; i < REF_BITS; i++) begin : g_ref_src
        assign src[i+1] = ref_cnt[i];
    end
    assign src[REF_BITS+1] = half_wave;
    assign src[REF_BITS+2] = now.sec[0];
    assign src[REF_BITS+3] = now.sec[4];
    assign src[REF_BITS+4] = now.min[0];
    assign src[REF_BITS+5] = now.hr[0];
    assign src[REF_BITS+6] = now.date[0];
    assign src[REF_BITS+7] = now.mon[0];

    assign wave_nxt = src[wave_sel];

    always_ff @(posedge clk) begin
        if (rst) begin
            clkout  <= 1'b0;
            hit_q   <= 1'b0;
            alarm_f <= 1'b0;
            wave_f  <= 1'b0;
        end else begin
            clkout  <= wave_nxt;
            hit_q   <= alarm_hit;
            // A new event in the reading cycle survives the clear
            alarm_f <= (alarm_f & ~status_rd) | (alarm_hit & ~hit_q);
            wave_f  <= (wave_f & ~status_rd) | (wave_nxt & ~clkout);
        end
    end

    always_comb begin
        status           = '0;
        status[ST_ALARM] = alarm_f;
        status[ST_WAVE]  = wave_f;
    end

    assign irq_n = ~(alarm_f | wave_f);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter int DIV_BASE = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] addr,
    input  logic       wr,
    input  logic       rd,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq_n,
    output logic       clkout
);

    rtc_ctrl_t            ctrl_q;
    rtc_time_t            now, snap_q;
    logic [NUM_CNT-1:0]   cnt_wr;
    logic [NUM_ALARM-1:0] latch_wr;
    logic                 tick, half_wave, alarm_hit, status_rd;
    logic [REF_BITS-1:0]  ref_cnt;
    logic [7:0]           status;

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt_wr
        if (i < NUM_ALARM) begin : g_redir
            assign cnt_wr[i]   = wr && (addr == 3'(i)) && !ctrl_q.alarm_mode;
            assign latch_wr[i] = wr && (addr == 3'(i)) &&  ctrl_q.alarm_mode;
        end else begin : g_plain
            assign cnt_wr[i]   = wr && (addr == 3'(i));
        end
    end

    assign status_rd = rd && (addr == A_CTRL);

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (wr && addr == A_CTRL)
            ctrl_q <= rtc_ctrl_t'(wdata);
    end

    rtc_prescaler #(.DIV_BASE(DIV_BASE)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .run       (ctrl_q.run),
        .clear     (cnt_wr[0]),
        .pre_sel   (ctrl_q.pre_sel),
        .tick      (tick),
        .half_wave (half_wave),
        .ref_cnt   (ref_cnt)
    );

    rtc_counter_chain u_chain (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .wr_en (cnt_wr),
        .wdata (wdata),
        .now   (now)
    );

    rtc_alarm_irq u_alarm (
        .clk        (clk),
        .rst        (rst),
        .now        (now),
        .latch_wr   (latch_wr),
        .wdata      (wdata),
        .alarm_mode (ctrl_q.alarm_mode),
        .wave_sel   (ctrl_q.wave_sel),
        .ref_cnt    (ref_cnt),
        .half_wave  (half_wave),
        .status_rd  (status_rd),
        .alarm_hit  (alarm_hit),
        .irq_n      (irq_n),
        .clkout     (clkout),
        .status     (status)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= TIME_RESET;
            rdata  <= '0;
        end else if (rd) begin
            case (rtc_addr_e'(addr))
                A_SEC: begin
                    rdata  <= now.sec;
                    snap_q <= now;
                end
                A_MIN:   rdata <= snap_q.min;
                A_HR:    rdata <= snap_q.hr;
                A_DATE:  rdata <= snap_q.date;
                A_MON:   rdata <= snap_q.mon;
                A_CTRL:  rdata <= status;
                default: rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] addr,
    input logic       wr,
    input logic       rd,
    input logic [7:0] wdata,
    input logic       irq_n,
    input logic       tick,
    input logic       run,
    input logic       alarm_mode,
    input logic [3:0] wave_sel,
    input logic       alarm_hit,
    input logic [7:0] sec,
    input logic [7:0] min
);

    // R2: a chain stopped for two cycles keeps seconds unless written
    assert_stop_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (!run && !$past(run) && !wr) |=> $stable(sec));

    // R2: ticks are single-cycle pulses
    assert_tick_single_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R3: seconds wrap from 59 to 00
    assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr && sec == 8'h59) |=> (sec == 8'h00));

    // R4: a counter write lands at the minutes address
    assert_min_write_R4: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == 3'd1 && !alarm_mode) |=> (min == $past(wdata)));

    // R6: an alarm-mode write does not touch the seconds counter
    assert_redirect_R6: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == 3'd0 && alarm_mode && !tick) |=> $stable(sec));

    // R7: a fresh alarm match pulls the interrupt low
    assert_alarm_irq_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(alarm_hit) |=> !irq_n);

    // R10: a status read with no source armed releases the interrupt
    assert_status_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == 3'd7 && !alarm_mode && wave_sel == 4'd0) |=> irq_n);

endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .wr         (wr),
    .rd         (rd),
    .wdata      (wdata),
    .irq_n      (irq_n),
    .tick       (tick),
    .run        (ctrl_q.run),
    .alarm_mode (ctrl_q.alarm_mode),
    .wave_sel   (ctrl_q.wave_sel),
    .alarm_hit  (alarm_hit),
    .sec        (now.sec),
    .min        (now.min)
);

// File: tb/rtc_calendar_tb.sv
module rtc_calendar_tb;

    localparam int DIV_BASE = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr = '0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_n;
    logic       clkout;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rtc_calendar #(.DIV_BASE(DIV_BASE)) u_dut (
        .clk    (clk),
        .rst    (rst),
        .addr   (addr),
        .wr     (wr),
        .rd     (rd),
        .wdata  (wdata),
        .rdata  (rdata),
        .irq_n  (irq_n),
        .clkout (clkout)
    );

    task automatic chk8(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic chk1(input string req, input logic got, input logic exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    // Called at a falling edge; the access happens at the next rising edge
    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                            input logic [7:0] d, input logic [7:0] mo);
        bus_wr(3'd7, 8'h00);
        bus_wr(3'd0, s);
        bus_wr(3'd1, m);
        bus_wr(3'd2, h);
        bus_wr(3'd3, d);
        bus_wr(3'd4, mo);
    endtask

    task automatic expect_time(input string req, input logic [7:0] s, input logic [7:0] m,
                               input logic [7:0] h, input logic [7:0] d, input logic [7:0] mo);
        logic [7:0] v;
        bus_rd(3'd0, v); chk8({req, " sec"}, v, s);
        bus_rd(3'd1, v); chk8({req, " min"}, v, m);
        bus_rd(3'd2, v); chk8({req, " hr"}, v, h);
        bus_rd(3'd3, v); chk8({req, " date"}, v, d);
        bus_rd(3'd4, v); chk8({req, " month"}, v, mo);
    endtask

    // Runs at divisor 8 long enough for exactly one tick, then stops
    task automatic one_second();
        bus_wr(3'd7, 8'h01);
        repeat (11) @(negedge clk);
        bus_wr(3'd7, 8'h00);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk1("R1 irq_n", irq_n, 1'b1);
        chk1("R1 clkout", clkout, 1'b0);
        chk8("R1 rdata", rdata, 8'h00);
        expect_time("R1", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01);
        bus_rd(3'd7, v); chk8("R1 status", v, 8'h00);
    endtask

    task automatic t_map();
        logic [7:0] v;
        set_time(8'h42, 8'h17, 8'h09, 8'h15, 8'h06);
        expect_time("R4 map", 8'h42, 8'h17, 8'h09, 8'h15, 8'h06);
        bus_wr(3'd5, 8'hAA);
        bus_wr(3'd6, 8'h55);
        bus_rd(3'd5, v); chk8("R4 addr5", v, 8'h00);
        bus_rd(3'd6, v); chk8("R4 addr6", v, 8'h00);
        expect_time("R4 reserved writes", 8'h42, 8'h17, 8'h09, 8'h15, 8'h06);
    endtask

    task automatic t_prescale();
        logic [7:0] v;
        set_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01);
        bus_wr(3'd7, 8'h01);                 // divisor 8
        repeat (20) @(negedge clk);
        bus_rd(3'd0, v); chk8("R2 div8", v, 8'h02);
        bus_wr(3'd7, 8'h00);
        bus_wr(3'd0, 8'h00);
        bus_wr(3'd7, 8'h03);                 // divisor 16
        repeat (56) @(negedge clk);
        bus_rd(3'd0, v); chk8("R2 div16", v, 8'h03);
        bus_wr(3'd7, 8'h00);
        bus_wr(3'd0, 8'h00);
        bus_wr(3'd7, 8'h05);                 // divisor 32
        repeat (80) @(negedge clk);
        bus_rd(3'd0, v); chk8("R2 div32", v, 8'h02);
        bus_wr(3'd7, 8'h00);
    endtask

    task automatic t_stop();
        logic [7:0] a, b;
        bus_rd(3'd0, a);
        repeat (100) @(negedge clk);
        bus_rd(3'd0, b); chk8("R2 stopped", b, a);
        bus_wr(3'd7, 8'h30);
        bus_rd(3'd7, b); chk8("R5 ctrl not readable", b, 8'h00);
        bus_wr(3'd7, 8'h00);
    endtask

    task automatic t_roll();
        set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02); one_second();
        expect_time("R3 feb end", 8'h00, 8'h00, 8'h00, 8'h01, 8'h03);
        set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h04); one_second();
        expect_time("R3 30-day end", 8'h00, 8'h00, 8'h00, 8'h01, 8'h05);
        set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h12); one_second();
        expect_time("R3 year end", 8'h00, 8'h00, 8'h00, 8'h01, 8'h01);
        set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h01); one_second();
        expect_time("R3 jan 30", 8'h00, 8'h00, 8'h00, 8'h31, 8'h01);
        set_time(8'h09, 8'h19, 8'h05, 8'h09, 8'h09); one_second();
        expect_time("R3 digit carry", 8'h10, 8'h19, 8'h05, 8'h09, 8'h09);
        set_time(8'h59, 8'h09, 8'h19, 8'h09, 8'h09); one_second();
        expect_time("R3 min carry", 8'h00, 8'h10, 8'h19, 8'h09, 8'h09);
    endtask

    task automatic t_redirect();
        set_time(8'h12, 8'h34, 8'h05, 8'h07, 8'h08);
        bus_wr(3'd7, 8'h08);
        bus_wr(3'd0, 8'h50);
        bus_wr(3'd1, 8'h40);
        bus_wr(3'd2, 8'h07);
        bus_wr(3'd3, 8'h20);
        expect_time("R6 redirect", 8'h12, 8'h34, 8'h05, 8'h20, 8'h08);
        bus_wr(3'd7, 8'h00);
    endtask

    task automatic t_alarm();
        logic [7:0] v;
        set_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01);
        bus_wr(3'd7, 8'h08);
        bus_wr(3'd0, 8'h05);
        bus_wr(3'd1, 8'h00);
        bus_wr(3'd2, 8'h00);
        bus_rd(3'd7, v);                     // drop the match seen while latches were zero
        chk1("R10 irq after clear", irq_n, 1'b1);
        bus_wr(3'd7, 8'h09);
        repeat (36) @(negedge clk);
        chk1("R7 before match", irq_n, 1'b1);
        repeat (8) @(negedge clk);
        chk1("R7 at match", irq_n, 1'b0);
        bus_wr(3'd7, 8'h08);
        bus_rd(3'd7, v); chk8("R10 alarm status", v, 8'h80);
        chk1("R10 irq released", irq_n, 1'b1);
        bus_wr(3'd7, 8'h00);
    endtask

    task automatic t_alarm_off();
        logic [7:0] v;
        bus_wr(3'd0, 8'h00);
        bus_wr(3'd7, 8'h01);
        repeat (44) @(negedge clk);
        chk1("R7 disabled irq", irq_n, 1'b1);
        bus_wr(3'd7, 8'h00);
        bus_rd(3'd7, v); chk8("R7 disabled status", v, 8'h00);
    endtask

    task automatic t_wave_fast();
        logic a, b;
        logic [7:0] v;
        bus_wr(3'd7, 8'h10);
        repeat (2) @(negedge clk);
        a = clkout;
        @(negedge clk);
        b = clkout;
        chk1("R8 select 1 toggles", b, ~a);
        chk1("R9 wave irq", irq_n, 1'b0);
        bus_wr(3'd7, 8'h00);
        bus_rd(3'd7, v); chk8("R10 wave status", v, 8'h40);
        chk1("R10 irq released", irq_n, 1'b1);
        repeat (10) @(negedge clk);
        chk1("R8 select 0 low", clkout, 1'b0);
        chk1("R8 select 0 no irq", irq_n, 1'b1);
    endtask

    task automatic t_wave_sec();
        logic [7:0] v;
        bus_wr(3'd0, 8'h00);
        bus_wr(3'd7, 8'hA1);                 // select 10, run, divisor 8
        repeat (4) @(negedge clk);
        chk1("R9 before second", irq_n, 1'b1);
        repeat (8) @(negedge clk);
        chk1("R9 seconds edge irq", irq_n, 1'b0);
        chk1("R8 seconds lsb", clkout, 1'b1);
        bus_wr(3'd7, 8'h00);
        bus_rd(3'd7, v); chk8("R9 status", v, 8'h40);
    endtask

    task automatic t_sec_clear();
        logic [7:0] v;
        bus_wr(3'd0, 8'h00);
        bus_wr(3'd7, 8'h01);
        repeat (12) @(negedge clk);
        bus_wr(3'd0, 8'h30);                 // mid-second
        repeat (4) @(negedge clk);
        bus_rd(3'd0, v); chk8("R11 no early tick", v, 8'h30);
        repeat (8) @(negedge clk);
        bus_rd(3'd0, v); chk8("R11 full period", v, 8'h31);
        bus_wr(3'd7, 8'h00);
    endtask

    task automatic t_snapshot();
        logic [7:0] v;
        set_time(8'h59, 8'h10, 8'h03, 8'h02, 8'h02);
        bus_wr(3'd7, 8'h01);
        repeat (4) @(negedge clk);
        bus_rd(3'd0, v); chk8("R12 sec before tick", v, 8'h59);
        repeat (6) @(negedge clk);
        bus_rd(3'd1, v); chk8("R12 held minutes", v, 8'h10);
        bus_rd(3'd0, v); chk8("R12 sec after tick", v, 8'h00);
        bus_rd(3'd1, v); chk8("R12 fresh minutes", v, 8'h11);
        bus_wr(3'd7, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_map();
        t_prescale();
        t_stop();
        t_roll();
        t_redirect();
        t_alarm();
        t_alarm_off();
        t_wave_fast();
        t_wave_sec();
        t_sec_clear();
        t_snapshot();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule